// File: doc/BRIEF.md
# Small-Operand Decimal-Split ALU

A purely combinational arithmetic unit for two 3-bit unsigned operands. A 2-bit select picks addition, subtraction, multiplication or truncating division. The result lies between 0 and 49 and leaves the block already split into a decimal tens digit and a decimal units digit, each a 4-bit binary value. A digit-scanning display stage can consume the digits without further conversion.

Two flags go with the digits. The error flag rejects a subtraction whose result would be negative and any division by zero. The zero flag marks a valid result of zero. When the error flag is high, both digits read zero and the zero flag stays low, so a downstream consumer never treats a rejected operation as a real number.

Top module: `mini_alu_dec`

## Requirements
- R1: The select encodes 2'b00 add, 2'b01 subtract, 2'b10 multiply and 2'b11 divide. Select 2'b00 yields a_i + b_i.
- R2: Addition (2'b00) and multiplication (2'b10, result a_i * b_i) never raise err_o.
- R3: Subtraction (2'b01) yields a_i - b_i when a_i >= b_i. When a_i < b_i it raises err_o.
- R4: Division (2'b11) yields the truncated quotient a_i / b_i, with the remainder discarded, when b_i != 0. When b_i == 0 it raises err_o.
- R5: For a valid result v, tens_o = v / 10 and units_o = v % 10. units_o never exceeds 9.
- R6: 7 * 7 gives tens_o = 4 and units_o = 9. tens_o never exceeds 4 for any input.
- R7: While err_o is high, tens_o and units_o are both 0 and zero_o is low.
- R8: zero_o is high exactly when the operation is valid and its result is 0.
- R9: All outputs depend only on the present inputs. There is no clock and no stored state, and a new input pattern is reflected at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 3 | First operand, unsigned |
| b_i | input | 3 | Second operand, unsigned |
| op_i | input | 2 | Operation select |
| tens_o | output | 4 | Decimal tens digit of the result |
| units_o | output | 4 | Decimal units digit of the result |
| zero_o | output | 1 | Valid result equals zero |
| err_o | output | 1 | Operation rejected |

## Verification
Every output is due in the same evaluation as its stimulus: the latency is zero cycles and no clock edge is involved. The bench changes the inputs and waits a fixed 1 ns settle delay before it samples. It never waits on the bench clock, so no result depends on edge ordering. A vector table covers the named corners. A sweep of all 256 operand and select combinations then compares each output against a reference model in the bench, built from plain integer arithmetic. A final check changes the inputs back to back, with no clock in between, to show that nothing is held over.

// File: rtl/alu_dec_pkg.sv
package alu_dec_pkg;
  localparam int OP_W   = 3;
  localparam int SEL_W  = 2;
  localparam int RES_W  = 2 * OP_W;
  localparam int DIG_W  = 4;
  localparam int MAX_V  = ((1 << OP_W) - 1) * ((1 << OP_W) - 1);

  function automatic int n_digits(input int v);
    int n;
    n = 1;
    while (v >= 10) begin
      v = v / 10;
      n++;
    end
    return n;
  endfunction

  localparam int N_DIG = n_digits(MAX_V);
  localparam int BCD_W = N_DIG * DIG_W;

  typedef enum logic [SEL_W-1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MUL = 2'b10,
    OP_DIV = 2'b11
  } op_e;
endpackage

// File: rtl/alu_dec_mul.sv
module alu_dec_mul #(
  parameter int W = 3
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  localparam int PW = 2 * W;

  logic [PW-1:0] acc [W+1];
  assign acc[0] = '0;

  for (genvar i = 0; i < W; i++) begin : g_row
    logic [PW-1:0] pp;
    assign pp       = b_i[i] ? ({{W{1'b0}}, a_i} << i) : '0;
    assign acc[i+1] = acc[i] + pp;
  end

  assign p_o = acc[W];
endmodule

// File: rtl/alu_dec_div.sv
module alu_dec_div #(
  parameter int W = 3
) (
  input  logic [W-1:0] n_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // restoring divider, one stage per quotient bit, MSB first
  logic [W:0] rem [W+1];
  assign rem[0] = '0;

  for (genvar s = 0; s < W; s++) begin : g_stage
    localparam int BIT = W - 1 - s;
    logic [W:0] trial;
    logic       fit;
    assign trial      = {rem[s][W-1:0], n_i[BIT]};
    assign fit        = (trial >= {1'b0, d_i}) && (d_i != '0);
    assign q_o[BIT]   = fit;
    assign rem[s+1]   = fit ? (trial - {1'b0, d_i}) : trial;
  end
endmodule

// File: rtl/alu_dec_bcd.sv
module alu_dec_bcd #(
  parameter int BW    = 6,
  parameter int NDIG  = 2
) (
  input  logic [BW-1:0]     bin_i,
  output logic [NDIG*4-1:0] bcd_o
);
  // shift-and-add-3 conversion, one stage per input bit
  logic [NDIG*4-1:0] st [BW+1];
  assign st[0] = '0;

  for (genvar s = 0; s < BW; s++) begin : g_shift
    logic [NDIG*4-1:0] adj;
    for (genvar d = 0; d < NDIG; d++) begin : g_dig
      logic [3:0] nib;
      assign nib            = st[s][d*4 +: 4];
      assign adj[d*4 +: 4]  = (nib >= 4'd5) ? nib + 4'd3 : nib;
    end
    assign st[s+1] = {adj[NDIG*4-2:0], bin_i[BW-1-s]};
  end

  assign bcd_o = st[BW];
endmodule

// File: rtl/mini_alu_dec.sv
module mini_alu_dec
  import alu_dec_pkg::*;
(
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  input  logic [SEL_W-1:0] op_i,
  output logic [DIG_W-1:0] tens_o,
  output logic [DIG_W-1:0] units_o,
  output logic             zero_o,
  output logic             err_o
);
  logic [RES_W-1:0] prod;
  logic [OP_W-1:0]  quot;
  logic [OP_W:0]    diff;
  logic [RES_W-1:0] res;
  logic [BCD_W-1:0] bcd;
  logic             bad;

  alu_dec_mul #(.W(OP_W)) u_mul (.a_i(a_i), .b_i(b_i), .p_o(prod));
  alu_dec_div #(.W(OP_W)) u_div (.n_i(a_i), .d_i(b_i), .q_o(quot));

  assign diff = {1'b0, a_i} - {1'b0, b_i};

  always_comb begin
    res = '0;
    bad = 1'b0;
    unique case (op_e'(op_i))
      OP_ADD: res = RES_W'({1'b0, a_i} + {1'b0, b_i});
      OP_SUB: begin
        bad = diff[OP_W];  // borrow out: negative result
        res = RES_W'(diff[OP_W-1:0]);
      end
      OP_MUL: res = prod;
      OP_DIV: begin
        bad = (b_i == '0);
        res = RES_W'(quot);
      end
      default: res = '0;
    endcase
  end

  alu_dec_bcd #(.BW(RES_W), .NDIG(N_DIG)) u_bcd (.bin_i(res), .bcd_o(bcd));

  assign err_o   = bad;
  assign units_o = bad ? '0 : bcd[0 +: DIG_W];
  assign tens_o  = bad ? '0 : bcd[DIG_W +: DIG_W];
  assign zero_o  = !bad && (res == '0);
endmodule

// File: rtl/mini_alu_dec_chk.sv
module mini_alu_dec_chk
  import alu_dec_pkg::*;
(
  input logic [OP_W-1:0]  a_i,
  input logic [OP_W-1:0]  b_i,
  input logic [SEL_W-1:0] op_i,
  input logic [DIG_W-1:0] tens_o,
  input logic [DIG_W-1:0] units_o,
  input logic             zero_o,
  input logic             err_o
);
  always_comb begin
    AST_ADD_MUL_NO_ERR: assert (!(op_i == 2'b00 || op_i == 2'b10) || !err_o)
      else $error("add/mul raised error"); // R2
    AST_SUB_NEG_ERR: assert (!(op_i == 2'b01 && a_i < b_i) || err_o)
      else $error("negative subtract not flagged"); // R3
    AST_DIV_ZERO_ERR: assert (!(op_i == 2'b11 && b_i == '0) || err_o)
      else $error("divide by zero not flagged"); // R4
    AST_UNITS_DIGIT: assert (units_o <= 4'd9)
      else $error("units digit out of range"); // R5
    AST_TENS_MAX: assert (tens_o <= 4'd4)
      else $error("tens digit above 4"); // R6
    AST_ERR_CLEARS: assert (!err_o || (tens_o == '0 && units_o == '0 && !zero_o))
      else $error("error outputs not cleared"); // R7
    AST_ZERO_DIGITS: assert (!zero_o || (tens_o == '0 && units_o == '0 && !err_o))
      else $error("zero flag with nonzero digits"); // R8
  end
endmodule

bind mini_alu_dec mini_alu_dec_chk u_chk (
  .a_i(a_i), .b_i(b_i), .op_i(op_i),
  .tens_o(tens_o), .units_o(units_o), .zero_o(zero_o), .err_o(err_o)
);

// File: tb/mini_alu_dec_test.sv
`timescale 1ns/1ps
module mini_alu_dec_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] a, b;
  logic [1:0] op;
  logic [3:0] tens, units;
  logic       zero, err;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  mini_alu_dec uut (
    .a_i(a), .b_i(b), .op_i(op),
    .tens_o(tens), .units_o(units), .zero_o(zero), .err_o(err)
  );

  typedef struct packed {
    logic [1:0] op;
    logic [2:0] a;
    logic [2:0] b;
    logic [3:0] tens;
    logic [3:0] units;
    logic       zero;
    logic       err;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{2'b00, 3'd7, 3'd7, 4'd1, 4'd4, 1'b0, 1'b0},  // R1 add 14
    '{2'b00, 3'd0, 3'd0, 4'd0, 4'd0, 1'b1, 1'b0},  // R8 add zero
    '{2'b01, 3'd5, 3'd3, 4'd0, 4'd2, 1'b0, 1'b0},  // R3 sub ok
    '{2'b01, 3'd3, 3'd5, 4'd0, 4'd0, 1'b0, 1'b1},  // R3 R7 sub neg
    '{2'b01, 3'd4, 3'd4, 4'd0, 4'd0, 1'b1, 1'b0},  // R8 sub equal
    '{2'b10, 3'd7, 3'd7, 4'd4, 4'd9, 1'b0, 1'b0},  // R6 max
    '{2'b10, 3'd6, 3'd0, 4'd0, 4'd0, 1'b1, 1'b0},  // R2 mul zero
    '{2'b10, 3'd3, 3'd4, 4'd1, 4'd2, 1'b0, 1'b0},  // R5 mul 12
    '{2'b11, 3'd7, 3'd2, 4'd0, 4'd3, 1'b0, 1'b0},  // R4 truncate
    '{2'b11, 3'd5, 3'd0, 4'd0, 4'd0, 1'b0, 1'b1},  // R4 R7 div0
    '{2'b11, 3'd0, 3'd3, 4'd0, 4'd0, 1'b1, 1'b0},  // R8 div 0/3
    '{2'b11, 3'd6, 3'd7, 4'd0, 4'd0, 1'b1, 1'b0}   // R4 6/7
  };

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s op=%0d a=%0d b=%0d act={t%0d u%0d z%0d e%0d} exp={t%0d u%0d z%0d e%0d}",
               req, op, a, b, act[9:6], act[5:2], act[1], act[0],
               exp[9:6], exp[5:2], exp[1], exp[0]);
    end
  endtask

  task automatic apply(input logic [1:0] o, input logic [2:0] x, input logic [2:0] y);
    op = o; a = x; b = y;
    #1;
  endtask

  function automatic logic [9:0] model(input logic [1:0] o, input int x, input int y);
    int  v;
    bit  e;
    v = 0; e = 1'b0;
    case (o)
      2'b00: v = x + y;
      2'b01: if (x >= y) v = x - y; else e = 1'b1;
      2'b10: v = x * y;
      default: if (y != 0) v = x / y; else e = 1'b1;
    endcase
    if (e) return {4'd0, 4'd0, 1'b0, 1'b1};
    return {4'(v / 10), 4'(v % 10), (v == 0), 1'b0};
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    op = 2'b00; a = '0; b = '0;
    #1;
    // R8: idle inputs (0 + 0) give a valid zero
    check("R8 idle", {tens, units, zero, err}, {4'd0, 4'd0, 1'b1, 1'b0});
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i].op, TBL[i].a, TBL[i].b);
      check("R1-table", {tens, units, zero, err},
            {TBL[i].tens, TBL[i].units, TBL[i].zero, TBL[i].err});
    end

    // exhaustive sweep: R1 R2 R3 R4 R5 R6 R7 R8
    for (int o = 0; o < 4; o++)
      for (int x = 0; x < 8; x++)
        for (int y = 0; y < 8; y++) begin
          apply(2'(o), 3'(x), 3'(y));
          check("R5 sweep", {tens, units, zero, err}, model(2'(o), x, y));
          if (tens > 4'd4) check("R6 tens max", {tens, 6'd0}, {4'd4, 6'd0});
        end

    // R9: back-to-back changes with no clock between
    @(negedge clk);
    apply(2'b10, 3'd7, 3'd7);
    apply(2'b01, 3'd2, 3'd6);
    check("R9 no hold", {tens, units, zero, err}, {4'd0, 4'd0, 1'b0, 1'b1});
    apply(2'b00, 3'd6, 3'd3);
    check("R9 follow", {tens, units, zero, err}, {4'd0, 4'd9, 1'b0, 1'b0});

    done = 1'b1;
    summary();
  end
endmodule